// File: doc/BRIEF.md
# Audio DMA Controller Global Reset and Interrupt Unit

This unit holds the controller-wide control word of a multi-channel audio DMA engine. It sequences cold and warm reset for the per-channel register sets, and it gates every other host write while the controller is held in cold reset. It sits between the host register port and the channel register blocks. Host writes carry an offset, an access size (byte, word or dword) and data. Writes to offsets this unit does not own are passed on to the channel blocks through a forward strobe, and only while the controller is out of cold reset.

The unit owns three offsets. The control word is at 0x2C and takes dword writes only. The read-only interrupt status word is at 0x30. A one-byte semaphore is at 0x34. Each channel raises its own interrupt request. The unit registers these requests into per-channel status bits and ORs them into one interrupt line. A warm reset request clears itself and produces a one-cycle pulse that stops the channels. The pulse is refused while any channel reports that it is running.

Top module: `aud_glob_reset`

## Requirements
- R1: After rst_n the control word reads 0, the unit is in cold reset, chan_clr_o is high, and the status word, semaphore and irq_o are all 0.
- R2: While control bit 1 (release) is 0, every host write is discarded except a dword write (size code 2) to 0x2C. The semaphore and control word keep their values and fwd_wr_o stays low.
- R3: A dword write to 0x2C with bit 1 clear stores data AND 0x70, clears the semaphore, and holds chan_clr_o high from the next cycle for as long as bit 1 stays clear.
- R4: A dword write to 0x2C with bit 1 set stores data AND 0xFB, so bit 2 never reads back as 1. chan_clr_o is low from the next cycle.
- R5: A dword write to 0x2C with bits 1 and 2 both set, while no run_i bit is set, gives a warm_rst_o pulse of exactly one cycle in the cycle after the write. chan_clr_o stays low.
- R6: The same warm request while any run_i bit is set gives no warm_rst_o pulse. The remaining bits are still stored as in R4.
- R7: Status bit i (bit position i of the word at 0x30) is chan_irq_i[i] registered on each clock edge. It is forced to 0 on any edge where the unit is in cold reset.
- R8: irq_o is high exactly when at least one status bit is set.
- R9: Writes of any size to 0x30 change nothing and are not forwarded.
- R10: When not in cold reset, a byte write (size code 0) to 0x34 stores data bits 7:0, and 0x34 reads that byte zero-extended. Word and dword writes to 0x34 are ignored.
- R11: A write to any offset other than 0x2C, 0x30 or 0x34 raises fwd_wr_o in the same cycle when not in cold reset. Byte and word writes to 0x2C are ignored and not forwarded.
- R12: A read of any offset other than 0x2C, 0x30 or 0x34 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 8 | Host write offset |
| wr_size_i | input | 2 | Access size: 0 byte, 1 word, 2 dword |
| wr_data_i | input | 32 | Host write data |
| rd_addr_i | input | 8 | Host read offset |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| run_i | input | 3 | Per-channel running flags |
| chan_irq_i | input | 3 | Per-channel interrupt requests |
| fwd_wr_o | output | 1 | Write accepted for the channel register blocks |
| chan_clr_o | output | 1 | Holds all channel register sets in reset |
| warm_rst_o | output | 1 | One-cycle warm reset pulse to the channels |
| irq_o | output | 1 | Shared interrupt output |

## Verification
Two functions can meet in one cycle. The first is a control write that leaves or enters cold reset. The second is a channel interrupt request, or a running flag, that is present on the same edge. The bench holds random chan_irq_i and run_i values steady across each control write, then reads the status word one idle cycle later. The expected status is zero if the post-write state is cold; otherwise it is the held request vector. A warm request made together with a running flag is judged by the absence of the pulse and by the stored control word.

// File: rtl/agr_pkg.sv
package agr_pkg;
  localparam int REG_W       = 32;
  localparam int RELEASE_BIT = 1;
  localparam int WARM_BIT    = 2;

  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_WORD  = 2'd1;
  localparam logic [1:0] SZ_DWORD = 2'd2;

  // Value stored by a control write: released writes keep the writable set,
  // cold writes keep only the stable set.
  function automatic logic [REG_W-1:0] ctrl_store(
      input logic [REG_W-1:0] d,
      input logic [REG_W-1:0] wr_mask,
      input logic [REG_W-1:0] keep_mask);
    logic [REG_W-1:0] r;
    if (d[RELEASE_BIT]) r = d & wr_mask & ~(REG_W'(1) << WARM_BIT);
    else                r = d & keep_mask;
    return r;
  endfunction

  // A warm reset is granted only with release set and no channel active.
  function automatic logic warm_grant(input logic [REG_W-1:0] d,
                                      input logic any_run);
    return d[RELEASE_BIT] & d[WARM_BIT] & ~any_run;
  endfunction
endpackage

// File: rtl/agr_ctrl.sv
module agr_ctrl
  import agr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter logic [REG_W-1:0] WR_MASK   = 32'h0000_00FB,
  parameter logic [REG_W-1:0] KEEP_MASK = 32'h0000_0070
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [NUM_CH-1:0] run_i,
  output logic [REG_W-1:0]  ctrl_q,
  output logic              cold_o,
  output logic              warm_o
);
  logic any_run;
  logic warm_q;

  assign any_run = |run_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      warm_q <= 1'b0;
    end else begin
      warm_q <= 1'b0;
      if (we_i) begin
        ctrl_q <= ctrl_store(wdata_i, WR_MASK, KEEP_MASK);
        warm_q <= warm_grant(wdata_i, any_run);
      end
    end
  end

  assign cold_o = ~ctrl_q[RELEASE_BIT];
  assign warm_o = warm_q;

  // R6
  warm_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && wdata_i[WARM_BIT] && any_run) |=> !warm_o);

  // R4
  warm_bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> !ctrl_q[WARM_BIT]);
endmodule

// File: rtl/agr_sema.sv
module agr_sema #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [SW-1:0] wdata_i,
  output logic [SW-1:0] sema_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sema_q <= '0;
    else if (clr_i) sema_q <= '0;
    else if (we_i)  sema_q <= wdata_i;
  end

  // R3
  sema_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (sema_q == '0));
endmodule

// File: rtl/agr_stat.sv
module agr_stat #(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_clr_i,
  input  logic [NUM_CH-1:0] irq_i,
  output logic [NUM_CH-1:0] stat_q,
  output logic              irq_o
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          stat_q[i] <= 1'b0;
      else if (hold_clr_i) stat_q[i] <= 1'b0;
      else                 stat_q[i] <= irq_i[i];
    end
  end

  assign irq_o = |stat_q;

  // R7
  stat_cold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_clr_i |=> (stat_q == '0));
endmodule

// File: rtl/aud_glob_reset.sv
module aud_glob_reset
  import agr_pkg::*;
#(
  parameter int AW     = 8,
  parameter int NUM_CH = 3,
  parameter int SEMA_W = 8,
  parameter logic [AW-1:0] CTRL_OFS = 8'h2C,
  parameter logic [AW-1:0] STAT_OFS = 8'h30,
  parameter logic [AW-1:0] SEMA_OFS = 8'h34,
  parameter logic [REG_W-1:0] WR_MASK   = 32'h0000_00FB,
  parameter logic [REG_W-1:0] KEEP_MASK = 32'h0000_0070
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [1:0]        wr_size_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic [NUM_CH-1:0] run_i,
  input  logic [NUM_CH-1:0] chan_irq_i,
  output logic              fwd_wr_o,
  output logic              chan_clr_o,
  output logic              warm_rst_o,
  output logic              irq_o
);
  localparam int STAT_PAD = REG_W - NUM_CH;
  localparam int SEMA_PAD = REG_W - SEMA_W;

  logic [REG_W-1:0]  ctrl_q;
  logic [NUM_CH-1:0] stat_q;
  logic [SEMA_W-1:0] sema_q;
  logic              cold;
  logic              owned;
  logic              ctrl_we;
  logic              sema_we;
  logic              cold_entry;

  // Decode of the host write.
  assign owned      = (wr_addr_i == CTRL_OFS) || (wr_addr_i == STAT_OFS) ||
                      (wr_addr_i == SEMA_OFS);
  assign ctrl_we    = wr_en_i && (wr_addr_i == CTRL_OFS) && (wr_size_i == SZ_DWORD);
  assign sema_we    = wr_en_i && !cold && (wr_addr_i == SEMA_OFS) &&
                      (wr_size_i == SZ_BYTE);
  assign cold_entry = ctrl_we && !wr_data_i[RELEASE_BIT];
  assign fwd_wr_o   = wr_en_i && !cold && !owned;

  agr_ctrl #(.NUM_CH(NUM_CH), .WR_MASK(WR_MASK), .KEEP_MASK(KEEP_MASK)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (ctrl_we),
    .wdata_i (wr_data_i),
    .run_i   (run_i),
    .ctrl_q  (ctrl_q),
    .cold_o  (cold),
    .warm_o  (warm_rst_o)
  );

  agr_sema #(.SW(SEMA_W)) u_sema (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (cold_entry),
    .we_i    (sema_we),
    .wdata_i (wr_data_i[SEMA_W-1:0]),
    .sema_q  (sema_q)
  );

  agr_stat #(.NUM_CH(NUM_CH)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_clr_i (cold),
    .irq_i      (chan_irq_i),
    .stat_q     (stat_q),
    .irq_o      (irq_o)
  );

  assign chan_clr_o = cold;

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == CTRL_OFS)      rd_data_o = ctrl_q;
    else if (rd_addr_i == STAT_OFS) rd_data_o = {{STAT_PAD{1'b0}}, stat_q};
    else if (rd_addr_i == SEMA_OFS) rd_data_o = {{SEMA_PAD{1'b0}}, sema_q};
  end

  // R2
  cold_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && cold && !ctrl_we) |=> ($stable(sema_q) && $stable(ctrl_q)));

  // R3
  cold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cold_entry |=> (chan_clr_o && ctrl_q == ($past(wr_data_i) & KEEP_MASK)));

  // R5
  warm_no_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst_o |-> (!chan_clr_o && !ctrl_q[WARM_BIT]));

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cold && (|chan_irq_i)) |=> irq_o);
endmodule

// File: tb/tb_aud_glob_reset.sv
module tb_aud_glob_reset;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [1:0]  wr_size = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [2:0]  run = '0;
  logic [2:0]  cirq = '0;
  logic        fwd, clr, warm, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] m_ctrl;
  logic [7:0]  m_sema;
  logic        warm_seen;
  logic        fwd_seen;

  always #5 clk = ~clk;

  aud_glob_reset dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_size_i(wr_size), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .run_i(run), .chan_irq_i(cirq), .fwd_wr_o(fwd),
    .chan_clr_o(clr), .warm_rst_o(warm), .irq_o(irq)
  );

  function automatic logic [31:0] exp_store(logic [31:0] d);
    return d[1] ? (d & 32'hFB) : (d & 32'h70);
  endfunction

  function automatic bit is_owned(logic [7:0] a);
    return (a == 8'h2C) || (a == 8'h30) || (a == 8'h34);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic host_wr(logic [7:0] a, logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_size = s; wr_data = d;
    #1 fwd_seen = fwd;
    @(posedge clk);
    #1 warm_seen = warm;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Apply a write to the model, check strobes, then one idle cycle and check state.
  task automatic step(logic [7:0] a, logic [1:0] s, logic [31:0] d);
    bit cold_b;
    bit exp_warm;
    logic [31:0] v;
    cold_b = !m_ctrl[1];
    exp_warm = 1'b0;
    host_wr(a, s, d);
    chk(cold_b ? "R2 fwd" : "R11 fwd", {31'd0, fwd_seen},
        {31'd0, !cold_b && !is_owned(a)});
    if (a == 8'h2C && s == 2'd2) begin
      exp_warm = d[1] && d[2] && (run == 3'b000);
      m_ctrl = exp_store(d);
      if (!d[1]) m_sema = 8'h00;
    end else if (!cold_b && a == 8'h34 && s == 2'd0) begin
      m_sema = d[7:0];
    end
    chk((d[2] && run != 0) ? "R6 warm" : "R5 warm", {31'd0, warm_seen}, {31'd0, exp_warm});
    @(posedge clk);
    #1;
    chk("R5 pulse width", {31'd0, warm}, 32'd0);
    rd(8'h2C, v); chk(d[1] ? "R4 ctrl" : "R3 ctrl", v, m_ctrl);
    rd(8'h34, v); chk("R10 sema", v, {24'd0, m_sema});
    rd(8'h30, v); chk("R7 status", v, m_ctrl[1] ? {29'd0, cirq} : 32'd0);
    chk("R8 irq", {31'd0, irq}, {31'd0, m_ctrl[1] && (cirq != 0)});
    chk("R3 chan_clr", {31'd0, clr}, {31'd0, !m_ctrl[1]});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    m_ctrl = '0; m_sema = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    rd(8'h2C, v); chk("R1 ctrl", v, 32'h0);
    rd(8'h30, v); chk("R1 status", v, 32'h0);
    rd(8'h34, v); chk("R1 sema", v, 32'h0);
    chk("R1 chan_clr", {31'd0, clr}, 32'd1);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    // R2 writes ignored while cold, request irq ignored too
    cirq = 3'b101;
    step(8'h34, 2'd0, 32'h5A);
    step(8'h10, 2'd2, 32'h1234);
    step(8'h2C, 2'd0, 32'h02);   // R11 byte to control ignored
    // release, then enable bits
    step(8'h2C, 2'd2, 32'h02);
    step(8'h2C, 2'd2, 32'h72);
    // R5 warm reset
    step(8'h34, 2'd0, 32'hAB);
    step(8'h2C, 2'd2, 32'h76);
    // R6 refused while running
    run = 3'b010;
    step(8'h2C, 2'd2, 32'h76);
    run = 3'b000;
    // R9 status write ignored
    step(8'h30, 2'd2, 32'hFFFF_FFFF);
    // R10 word write to semaphore ignored
    step(8'h34, 2'd1, 32'h00CC);
    // R12 unowned read
    rd(8'h40, v); chk("R12 unowned read", v, 32'h0);
    // R3 cold entry with enable bits
    step(8'h2C, 2'd2, 32'h70);
    step(8'h2C, 2'd2, 32'h03);
    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [7:0]  a;
      logic [31:0] d;
      case ($urandom % 5)
        0, 1: a = 8'h2C;
        2:    a = 8'h30;
        3:    a = 8'h34;
        default: a = 8'(4 * ($urandom % 11));
      endcase
      d = $urandom;
      if (a == 8'h2C && ($urandom % 4) != 0) d[1] = 1'b1;
      run  = 3'($urandom);
      cirq = 3'($urandom);
      step(a, 2'($urandom % 3), d);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule